// File: doc/BRIEF.md
# Single-Channel DMA Transfer Engine

This block is one DMA channel. Software programs a peripheral base address, a memory base address, an item count and a control word through a small register port, then sets the enable bit. Each item is moved as a read on a valid/ready master bus followed by a write of the same data word to the other side. The direction bit decides which side is read. Both addresses can step independently by the item size.

In peripheral mode, every item waits for a request pulse from the attached peripheral. The block answers each completed item with a one-cycle acknowledge. In memory-to-memory mode, the channel runs on its own until the count is exhausted. Circular mode reloads the count and both address pointers at the end of each pass, so a ring buffer is served without stopping. Three sticky flags are kept: half-transfer, transfer-complete and transfer-error. Each flag is cleared by writing 1 to its bit. The flags are combined with their enables into a single interrupt line. A bus error stops the channel at once. The 2-bit priority field is only stored and driven out for an external arbiter.

Top module: `dma_chan_engine`

## Requirements
- R1: After reset, the control, count and flag registers read 0, and `bus_req_valid`, `per_ack` and `irq` are low.
- R2: Register offsets are 0 control, 1 count, 2 peripheral base, 3 memory base, 4 flags. While the channel is enabled, writes to count and both bases are ignored. A control write then changes only the enable bit (bit 0).
- R3: In peripheral mode, an item starts only after a `per_req` pulse that arrived while enabled. Each completed item gives exactly one `per_ack` pulse. Memory-to-memory mode never pulses `per_ack`.
- R4: Control bit 4 selects the direction (0 = peripheral to memory, 1 = memory to peripheral). Each item reads the source and then writes the returned word, unchanged, to the destination. A request is held stable until `bus_req_ready`.
- R5: The size fields (peripheral [9:8], memory [11:10]) encode 00 = 8-bit, 01 = 16-bit, 10 = 32-bit and appear on `bus_req_size`. An address whose increment bit is set (peripheral bit 6, memory bit 7) steps by 1, 2 or 4 after each item; a clear bit holds it.
- R6: The count drops by one per completed item. It never goes below zero. Outside circular mode, the enable bit clears when the count reaches zero.
- R7: Flag bit 1 (half-transfer) sets on the item that leaves the count equal to the programmed count divided by two, rounded down.
- R8: Flag bit 0 (transfer-complete) sets on the item that brings the count to zero.
- R9: With circular bit 5 set (and bit 14 clear), the item that reaches zero reloads the programmed count and both base addresses, and the channel stays enabled.
- R10: With bit 14 set (memory-to-memory), items run back to back from enable until the count reaches zero. The circular bit is ignored in this mode.
- R11: An error response on a read or a write clears enable, sets flag bit 2, and does not count the item.
- R12: Writing 1 to a flag bit clears that flag only. `irq` is high while any flag is set together with its enable (bit 1 complete, bit 2 half, bit 3 error).
- R13: `chan_prio` carries control bits [13:12].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register offset |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for `cfg_addr` (combinational) |
| per_req | input | 1 | Peripheral request pulse |
| per_ack | output | 1 | One-cycle acknowledge per completed item |
| bus_req_valid | output | 1 | Bus request valid |
| bus_req_ready | input | 1 | Bus request accepted |
| bus_req_write | output | 1 | 1 = write, 0 = read |
| bus_req_addr | output | 32 | Byte address |
| bus_req_size | output | 2 | Access size code |
| bus_req_wdata | output | 32 | Write data |
| bus_rsp_valid | input | 1 | Response valid |
| bus_rsp_err | input | 1 | Response carries an error |
| bus_rsp_rdata | input | 32 | Read data |
| irq | output | 1 | Combined interrupt |
| chan_prio | output | 2 | Stored priority field |

## Verification
Register writes take effect at the next clock edge, and reads return the value in the same cycle. With a slave that accepts at once and answers one cycle after acceptance, an item finishes five edges after the request edge. The count, the flags and the enable change at that edge, and `per_ack` is high for the cycle after it. The bench waits at least fifteen cycles per item before it reads any result. It compares each bus write against a queue of expected items as the write is issued. For stimuli that must have no effect, it reads the untouched state back only after that same window has passed.

// File: rtl/dma_chan_pkg.sv
// Shared types for the DMA channel: configuration word, sequencer states,
// register offsets and the size-to-step helper.
package dma_chan_pkg;

    // Register offsets on the configuration port.
    localparam logic [2:0] OFF_CTRL  = 3'd0;
    localparam logic [2:0] OFF_COUNT = 3'd1;
    localparam logic [2:0] OFF_PBASE = 3'd2;
    localparam logic [2:0] OFF_MBASE = 3'd3;
    localparam logic [2:0] OFF_FLAGS = 3'd4;

    // Flag bit positions.
    localparam int FLG_TC = 0;
    localparam int FLG_HT = 1;
    localparam int FLG_TE = 2;

    // Control word bits [14:1]; the MSB-first order matches the write layout.
    typedef struct packed {
        logic       m2m;
        logic [1:0] prio;
        logic [1:0] msize;
        logic [1:0] psize;
        logic       minc;
        logic       pinc;
        logic       circ;
        logic       dir;
        logic       teie;
        logic       htie;
        logic       tcie;
    } chan_cfg_t;

    typedef enum logic [2:0] {
        S_IDLE,
        S_RD,
        S_RD_W,
        S_WR,
        S_WR_W
    } seq_state_t;

    // Byte step for a size code: 00 -> 1, 01 -> 2, others -> 4.
    function automatic logic [2:0] size_step(input logic [1:0] sz);
        case (sz)
            2'b00:   return 3'd1;
            2'b01:   return 3'd2;
            default: return 3'd4;
        endcase
    endfunction

endpackage

// File: rtl/dma_chan_regs.sv
// Register file for one channel: control word, enable, item count with its
// reload copy, base addresses and sticky flags.
// Assumes item_done/item_err are single-cycle strobes from the sequencer and
// never assert together.
module dma_chan_regs
    import dma_chan_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [2:0]        cfg_addr,
    input  logic [DATA_W-1:0] cfg_wdata,
    output logic [DATA_W-1:0] cfg_rdata,
    input  logic              item_done,
    input  logic              item_err,
    output logic              enable,
    output chan_cfg_t         cfg,
    output logic [CNT_W-1:0]  cnt,
    output logic [DATA_W-1:0] pbase,
    output logic [DATA_W-1:0] mbase,
    output logic [2:0]        flags,
    output logic              start,
    output logic              wrap
);
    localparam int CFG_W = $bits(chan_cfg_t);
    localparam int PAD_W = DATA_W - CNT_W;

    logic [CNT_W-1:0] cnt_init;
    logic             wr_ctrl, wr_cnt, wr_pb, wr_mb, wr_flg;
    logic             last, circ_eff, half_hit;
    logic [CNT_W-1:0] cnt_dec;

    // Decode write strobes; data registers are writable only while disabled.
    always_comb begin
        wr_ctrl = cfg_we && (cfg_addr == OFF_CTRL);
        wr_cnt  = cfg_we && (cfg_addr == OFF_COUNT) && !enable;
        wr_pb   = cfg_we && (cfg_addr == OFF_PBASE) && !enable;
        wr_mb   = cfg_we && (cfg_addr == OFF_MBASE) && !enable;
        wr_flg  = cfg_we && (cfg_addr == OFF_FLAGS);
    end

    // Derived item events: last item, circular wrap and half-way point.
    always_comb begin
        circ_eff = cfg.circ && !cfg.m2m;
        last     = (cnt == CNT_W'(1));
        cnt_dec  = cnt - CNT_W'(1);
        half_hit = (cnt_dec == (cnt_init >> 1));
        wrap     = item_done && last && circ_eff;
        start    = wr_ctrl && !enable && cfg_wdata[0];
    end

    // Enable bit and control fields; hardware clear wins over software.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            enable <= 1'b0;
            cfg    <= '0;
        end else begin
            if (wr_ctrl) begin
                enable <= cfg_wdata[0];
                if (!enable) cfg <= chan_cfg_t'(cfg_wdata[CFG_W:1]);
            end
            if (item_err || (item_done && last && !circ_eff)) enable <= 1'b0;
        end
    end

    // Item count and its reload copy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt      <= '0;
            cnt_init <= '0;
        end else if (wr_cnt) begin
            cnt      <= cfg_wdata[CNT_W-1:0];
            cnt_init <= cfg_wdata[CNT_W-1:0];
        end else if (item_done) begin
            cnt <= wrap ? cnt_init : cnt_dec;
        end
    end

    // Base addresses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pbase <= '0;
            mbase <= '0;
        end else begin
            if (wr_pb) pbase <= cfg_wdata;
            if (wr_mb) mbase <= cfg_wdata;
        end
    end

    // Sticky flags: set by events, cleared by writing 1; a set wins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags <= '0;
        end else begin
            flags <= (flags & ~(wr_flg ? cfg_wdata[2:0] : 3'b000))
                   | {item_err, item_done && half_hit, item_done && last};
        end
    end

    // Read-back multiplexer.
    always_comb begin
        case (cfg_addr)
            OFF_CTRL:  cfg_rdata = {{(DATA_W-CFG_W-1){1'b0}}, cfg, enable};
            OFF_COUNT: cfg_rdata = {{PAD_W{1'b0}}, cnt};
            OFF_PBASE: cfg_rdata = pbase;
            OFF_MBASE: cfg_rdata = mbase;
            OFF_FLAGS: cfg_rdata = {{(DATA_W-3){1'b0}}, flags};
            default:   cfg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/dma_chan_ptrs.sv
// Current peripheral and memory address pointers. Both load from their bases
// on channel start and on a circular wrap, and step by the item size after
// each completed item when their increment bit is set.
module dma_chan_ptrs
    import dma_chan_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              item_done,
    input  logic              wrap,
    input  logic [ADDR_W-1:0] pbase,
    input  logic [ADDR_W-1:0] mbase,
    input  logic              pinc,
    input  logic              minc,
    input  logic [1:0]        psize,
    input  logic [1:0]        msize,
    output logic [ADDR_W-1:0] pptr,
    output logic [ADDR_W-1:0] mptr
);
    localparam int NPTR = 2;

    logic [ADDR_W-1:0] base_a [NPTR];
    logic [ADDR_W-1:0] ptr_a  [NPTR];
    logic              inc_a  [NPTR];
    logic [1:0]        size_a [NPTR];

    // Gather per-pointer controls into arrays (0 = peripheral, 1 = memory).
    always_comb begin
        base_a[0] = pbase;  base_a[1] = mbase;
        inc_a[0]  = pinc;   inc_a[1]  = minc;
        size_a[0] = psize;  size_a[1] = msize;
        pptr      = ptr_a[0];
        mptr      = ptr_a[1];
    end

    for (genvar g = 0; g < NPTR; g++) begin : g_ptr
        // One pointer register: load, wrap or step.
        always_ff @(posedge clk) begin
            if (!rst_n)
                ptr_a[g] <= '0;
            else if (start || wrap)
                ptr_a[g] <= base_a[g];
            else if (item_done && inc_a[g])
                ptr_a[g] <= ptr_a[g] + ADDR_W'(size_step(size_a[g]));
        end
    end

endmodule

// File: rtl/dma_chan_seq.sv
// Item sequencer: waits for a request (or runs freely in memory-to-memory
// mode), issues the source read, then the destination write, over a
// valid/ready bus. Assumes one outstanding transaction and one response per
// accepted request.
module dma_chan_seq
    import dma_chan_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              m2m,
    input  logic              dir,
    input  logic [1:0]        psize,
    input  logic [1:0]        msize,
    input  logic [CNT_W-1:0]  cnt,
    input  logic [ADDR_W-1:0] pptr,
    input  logic [ADDR_W-1:0] mptr,
    input  logic              per_req,
    output logic              per_ack,
    output logic              bus_req_valid,
    input  logic              bus_req_ready,
    output logic              bus_req_write,
    output logic [ADDR_W-1:0] bus_req_addr,
    output logic [1:0]        bus_req_size,
    output logic [DATA_W-1:0] bus_req_wdata,
    input  logic              bus_rsp_valid,
    input  logic              bus_rsp_err,
    input  logic [DATA_W-1:0] bus_rsp_rdata,
    output logic              item_done,
    output logic              item_err
);
    seq_state_t        state, state_nx;
    logic              pend;
    logic [DATA_W-1:0] data_q;
    logic [ADDR_W-1:0] src, dst;
    logic [1:0]        src_sz, dst_sz;
    logic              in_wait;

    // Pick the source and destination sides from the direction bit.
    always_comb begin
        src    = dir ? mptr  : pptr;
        dst    = dir ? pptr  : mptr;
        src_sz = dir ? msize : psize;
        dst_sz = dir ? psize : msize;
    end

    // Completion strobes for the current item.
    always_comb begin
        in_wait   = (state == S_RD_W) || (state == S_WR_W);
        item_done = (state == S_WR_W) && bus_rsp_valid && !bus_rsp_err;
        item_err  = in_wait && bus_rsp_valid && bus_rsp_err;
    end

    // Next-state logic.
    always_comb begin
        state_nx = state;
        case (state)
            S_IDLE: if (enable && (cnt != '0) && (m2m || pend)) state_nx = S_RD;
            S_RD:   if (bus_req_ready) state_nx = S_RD_W;
            S_RD_W: if (bus_rsp_valid) state_nx = bus_rsp_err ? S_IDLE : S_WR;
            S_WR:   if (bus_req_ready) state_nx = S_WR_W;
            S_WR_W: if (bus_rsp_valid) state_nx = S_IDLE;
            default: state_nx = S_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    // Capture the read word for the following write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            data_q <= '0;
        else if ((state == S_RD_W) && bus_rsp_valid && !bus_rsp_err)
            data_q <= bus_rsp_rdata;
    end

    // Pending-request latch: one request per item, dropped while disabled.
    always_ff @(posedge clk) begin
        if (!rst_n) pend <= 1'b0;
        else        pend <= enable && (per_req || (pend && !(item_done || item_err)));
    end

    // Acknowledge pulse after each peripheral-mode item.
    always_ff @(posedge clk) begin
        if (!rst_n) per_ack <= 1'b0;
        else        per_ack <= item_done && !m2m;
    end

    // Bus request outputs.
    always_comb begin
        bus_req_valid = (state == S_RD) || (state == S_WR);
        bus_req_write = (state == S_WR);
        bus_req_addr  = (state == S_WR) ? dst : src;
        bus_req_size  = (state == S_WR) ? dst_sz : src_sz;
        bus_req_wdata = data_q;
    end

endmodule

// File: rtl/dma_chan_engine.sv
// Top level of one DMA channel: register file, address pointers and item
// sequencer. Priority is stored only and driven out for an external arbiter.
module dma_chan_engine
    import dma_chan_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [2:0]        cfg_addr,
    input  logic [ADDR_W-1:0] cfg_wdata,
    output logic [ADDR_W-1:0] cfg_rdata,
    input  logic              per_req,
    output logic              per_ack,
    output logic              bus_req_valid,
    input  logic              bus_req_ready,
    output logic              bus_req_write,
    output logic [ADDR_W-1:0] bus_req_addr,
    output logic [1:0]        bus_req_size,
    output logic [ADDR_W-1:0] bus_req_wdata,
    input  logic              bus_rsp_valid,
    input  logic              bus_rsp_err,
    input  logic [ADDR_W-1:0] bus_rsp_rdata,
    output logic              irq,
    output logic [1:0]        chan_prio
);
    logic              enable, start, wrap, item_done, item_err;
    chan_cfg_t         cfg;
    logic [CNT_W-1:0]  cnt;
    logic [ADDR_W-1:0] pbase, mbase, pptr, mptr;
    logic [2:0]        flags;

    dma_chan_regs #(.CNT_W(CNT_W), .DATA_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .item_done(item_done), .item_err(item_err),
        .enable(enable), .cfg(cfg), .cnt(cnt), .pbase(pbase), .mbase(mbase),
        .flags(flags), .start(start), .wrap(wrap)
    );

    dma_chan_ptrs #(.ADDR_W(ADDR_W)) u_ptrs (
        .clk(clk), .rst_n(rst_n),
        .start(start), .item_done(item_done), .wrap(wrap),
        .pbase(pbase), .mbase(mbase),
        .pinc(cfg.pinc), .minc(cfg.minc), .psize(cfg.psize), .msize(cfg.msize),
        .pptr(pptr), .mptr(mptr)
    );

    dma_chan_seq #(.CNT_W(CNT_W), .ADDR_W(ADDR_W), .DATA_W(ADDR_W)) u_seq (
        .clk(clk), .rst_n(rst_n),
        .enable(enable), .m2m(cfg.m2m), .dir(cfg.dir),
        .psize(cfg.psize), .msize(cfg.msize), .cnt(cnt),
        .pptr(pptr), .mptr(mptr),
        .per_req(per_req), .per_ack(per_ack),
        .bus_req_valid(bus_req_valid), .bus_req_ready(bus_req_ready),
        .bus_req_write(bus_req_write), .bus_req_addr(bus_req_addr),
        .bus_req_size(bus_req_size), .bus_req_wdata(bus_req_wdata),
        .bus_rsp_valid(bus_rsp_valid), .bus_rsp_err(bus_rsp_err),
        .bus_rsp_rdata(bus_rsp_rdata),
        .item_done(item_done), .item_err(item_err)
    );

    // Interrupt line and priority export.
    always_comb begin
        irq = (flags[FLG_TC] && cfg.tcie) || (flags[FLG_HT] && cfg.htie)
           || (flags[FLG_TE] && cfg.teie);
        chan_prio = cfg.prio;
    end

endmodule

// File: rtl/dma_chan_engine_chk.sv
// Property checker for dma_chan_engine, attached through bind.
module dma_chan_engine_chk #(
    parameter int CNT_W  = 16,
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_req_valid,
    input logic              bus_req_ready,
    input logic              bus_req_write,
    input logic [ADDR_W-1:0] bus_req_addr,
    input logic              per_ack,
    input logic              item_done,
    input logic              item_err,
    input logic              enable,
    input logic              m2m,
    input logic [CNT_W-1:0]  cnt,
    input logic [2:0]        flags
);
    // R4: a request stays put until accepted.
    assert_req_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req_valid && !bus_req_ready |=> bus_req_valid && $stable(bus_req_addr) && $stable(bus_req_write));

    // R6: count steps down by one on a completed non-final item.
    assert_count_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        item_done && enable && (cnt > CNT_W'(1)) |=> cnt == $past(cnt) - CNT_W'(1));

    // R6: an item never completes with the count already at zero.
    assert_no_underflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        item_done |-> cnt != '0);

    // R8: the final item raises the complete flag.
    assert_tc_on_last_R8: assert property (@(posedge clk) disable iff (!rst_n)
        item_done && enable && (cnt == CNT_W'(1)) |=> flags[0]);

    // R11: a bus error disables the channel and flags it.
    assert_err_stops_R11: assert property (@(posedge clk) disable iff (!rst_n)
        item_err |=> !enable && flags[2]);

    // R3: an acknowledge follows a completed peripheral-mode item.
    assert_ack_item_R3: assert property (@(posedge clk) disable iff (!rst_n)
        per_ack |-> $past(item_done) && !$past(m2m));

    // R3: a new read starts only from an enabled channel.
    assert_start_enabled_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_req_valid) && !bus_req_write |-> $past(enable));

endmodule

bind dma_chan_engine dma_chan_engine_chk #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n),
    .bus_req_valid(bus_req_valid), .bus_req_ready(bus_req_ready),
    .bus_req_write(bus_req_write), .bus_req_addr(bus_req_addr),
    .per_ack(per_ack), .item_done(item_done), .item_err(item_err),
    .enable(enable), .m2m(cfg.m2m), .cnt(cnt), .flags(flags)
);

// File: tb/dma_chan_engine_tb.sv
// Scoreboard bench: tasks push expected writes, a bus-slave monitor pops and
// compares each write as the engine issues it.
module dma_chan_engine_tb;
    localparam int AW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic [2:0]    cfg_addr = '0;
    logic [AW-1:0] cfg_wdata = '0;
    logic [AW-1:0] cfg_rdata;
    logic          per_req = 1'b0;
    logic          per_ack;
    logic          bus_req_valid, bus_req_write;
    logic          bus_req_ready = 1'b1;
    logic [AW-1:0] bus_req_addr, bus_req_wdata;
    logic [1:0]    bus_req_size;
    logic          bus_rsp_valid = 1'b0, bus_rsp_err = 1'b0;
    logic [AW-1:0] bus_rsp_rdata = '0;
    logic          irq;
    logic [1:0]    chan_prio;

    always #4 clk = ~clk;

    dma_chan_engine u_dut (.*);

    typedef struct { logic [AW-1:0] addr; logic [AW-1:0] data; logic [1:0] size; } item_t;
    item_t exp_q[$];

    int n_chk = 0, n_fail = 0, n_wr = 0, n_ack = 0;
    logic          err_en = 1'b0;
    logic [AW-1:0] err_addr = '0;
    logic          seen = 1'b0;
    logic [AW-1:0] s_addr = '0;

    function automatic logic [AW-1:0] mv(input logic [AW-1:0] a);
        return (a * 32'h0000_9E37) ^ 32'h5A5A_0F0F;
    endfunction

    function automatic logic [AW-1:0] ctrl(input bit en, tcie, htie, teie, dir, circ,
                                           pinc, minc, input logic [1:0] psz, msz, pr,
                                           input bit m2m);
        return {17'b0, m2m, pr, msz, psz, minc, pinc, circ, dir, teie, htie, tcie, en};
    endfunction

    task automatic check(input string req, input logic [AW-1:0] act, exp, input string what);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic reg_wr(input logic [2:0] a, input logic [AW-1:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic reg_rd(input logic [2:0] a, output logic [AW-1:0] d);
        @(negedge clk);
        cfg_addr = a;
        #1 d = cfg_rdata;
    endtask

    task automatic expect_item(input logic [AW-1:0] a, d, input logic [1:0] sz);
        item_t it;
        it.addr = a; it.data = d; it.size = sz;
        exp_q.push_back(it);
    endtask

    task automatic pulse_req();
        @(negedge clk); per_req = 1'b1;
        @(negedge clk); per_req = 1'b0;
        repeat (15) @(negedge clk);
    endtask

    // Bus slave and write monitor: accept at once, answer one cycle later.
    always @(negedge clk) begin
        bus_rsp_valid = 1'b0;
        bus_rsp_err   = 1'b0;
        if (seen) begin
            bus_rsp_valid = 1'b1;
            bus_rsp_rdata = mv(s_addr);
            bus_rsp_err   = err_en && (s_addr == err_addr);
            seen = 1'b0;
        end else if (rst_n && bus_req_valid) begin
            seen   = 1'b1;
            s_addr = bus_req_addr;
            if (bus_req_write) begin
                n_wr++;
                if (exp_q.size() == 0) begin
                    n_chk++; n_fail++;
                    $display("FAIL R4 unexpected write: actual addr %h expected none", bus_req_addr);
                end else begin
                    item_t e;
                    e = exp_q.pop_front();
                    check("R4", bus_req_addr, e.addr, "write address");
                    check("R4", bus_req_wdata, e.data, "write data");
                    check("R5", {30'b0, bus_req_size}, {30'b0, e.size}, "write size");
                end
            end
        end
    end

    always @(negedge clk) if (rst_n && per_ack) n_ack++;

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual running expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [AW-1:0] r;
        int w0, a0;

        repeat (3) @(negedge clk);
        // R1: reset state.
        check("R1", {31'b0, bus_req_valid}, 0, "valid in reset");
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        reg_rd(3'd0, r); check("R1", r, 0, "control");
        reg_rd(3'd1, r); check("R1", r, 0, "count");
        reg_rd(3'd4, r); check("R1", r, 0, "flags");
        check("R1", {30'b0, irq, per_ack}, 0, "irq/ack");

        // R10/R5/R7/R8: memory-to-memory, 32-bit, both increment.
        reg_wr(3'd2, 32'h1000); reg_wr(3'd3, 32'h2000); reg_wr(3'd1, 4);
        for (int i = 0; i < 4; i++) expect_item(32'h2000 + 4*i, mv(32'h1000 + 4*i), 2'b10);
        reg_wr(3'd0, ctrl(1,1,0,0,0,0,1,1,2'b10,2'b10,2'b00,1));
        repeat (60) @(negedge clk);
        check("R10", exp_q.size(), 0, "m2m items left");
        reg_rd(3'd1, r); check("R6", r, 0, "count after m2m");
        reg_rd(3'd0, r); check("R6", r[0], 0, "enable after m2m");
        reg_rd(3'd4, r); check("R8", r, 3, "flags after m2m (tc,ht)");
        check("R12", irq, 1, "irq with tc enabled");
        check("R10", n_ack, 0, "no ack in m2m");

        // Peripheral mode, memory to peripheral, 16-bit, fixed peripheral address.
        reg_wr(3'd4, 7);
        reg_wr(3'd2, 32'h3000); reg_wr(3'd3, 32'h4000); reg_wr(3'd1, 4);
        reg_wr(3'd0, ctrl(1,0,1,0,1,0,0,1,2'b01,2'b01,2'b10,0));
        check("R13", chan_prio, 2, "priority out");
        w0 = n_wr; a0 = n_ack;
        repeat (20) @(negedge clk);
        check("R3", n_wr - w0, 0, "no item without request");
        reg_wr(3'd1, 9);     reg_rd(3'd1, r); check("R2", r, 4, "count locked while enabled");
        reg_wr(3'd2, 32'hF0); reg_rd(3'd2, r); check("R2", r, 32'h3000, "base locked while enabled");
        expect_item(32'h3000, mv(32'h4000), 2'b01);
        pulse_req();
        reg_rd(3'd1, r); check("R6", r, 3, "count after item 1");
        check("R3", n_ack - a0, 1, "one ack per item");
        reg_rd(3'd4, r); check("R7", r, 0, "no half flag yet");
        expect_item(32'h3000, mv(32'h4002), 2'b01);
        pulse_req();
        reg_rd(3'd4, r); check("R7", r, 2, "half flag at count 2");
        check("R12", irq, 1, "irq from half flag");
        reg_wr(3'd4, 2);
        reg_rd(3'd4, r); check("R12", r, 0, "half flag cleared");
        check("R12", irq, 0, "irq dropped");
        expect_item(32'h3000, mv(32'h4004), 2'b01);
        pulse_req();
        expect_item(32'h3000, mv(32'h4006), 2'b01);
        pulse_req();
        reg_rd(3'd1, r); check("R6", r, 0, "count drained");
        reg_rd(3'd0, r); check("R6", r[0], 0, "enable cleared at zero");
        reg_rd(3'd4, r); check("R8", r, 1, "complete flag");
        check("R12", irq, 0, "tc not enabled");
        check("R3", n_ack - a0, 4, "ack total");
        w0 = n_wr;
        pulse_req();
        check("R3", n_wr - w0, 0, "request while disabled ignored");

        // R9: circular, 8-bit, two items per pass.
        reg_wr(3'd4, 7);
        reg_wr(3'd2, 32'h5000); reg_wr(3'd3, 32'h6000); reg_wr(3'd1, 2);
        reg_wr(3'd0, ctrl(1,0,0,0,0,1,1,1,2'b00,2'b00,2'b00,0));
        expect_item(32'h6000, mv(32'h5000), 2'b00); pulse_req();
        expect_item(32'h6001, mv(32'h5001), 2'b00); pulse_req();
        expect_item(32'h6000, mv(32'h5000), 2'b00); pulse_req();
        reg_rd(3'd1, r); check("R9", r, 1, "count reloaded");
        reg_rd(3'd0, r); check("R9", r[0], 1, "still enabled");
        reg_rd(3'd4, r); check("R8", r[0], 1, "tc on wrap");
        reg_wr(3'd0, 0);
        reg_rd(3'd0, r); check("R2", r[5], 1, "only enable changed while enabled");

        // R10: memory-to-memory ignores the circular bit.
        reg_wr(3'd2, 32'h5100); reg_wr(3'd3, 32'h6100); reg_wr(3'd1, 2);
        expect_item(32'h6100, mv(32'h5100), 2'b10);
        expect_item(32'h6104, mv(32'h5104), 2'b10);
        reg_wr(3'd0, ctrl(1,0,0,0,0,1,1,1,2'b10,2'b10,2'b00,1));
        repeat (40) @(negedge clk);
        reg_rd(3'd1, r); check("R10", r, 0, "m2m+circ stops");
        reg_rd(3'd0, r); check("R10", r[0], 0, "m2m+circ disabled");

        // R11: error on the second read.
        reg_wr(3'd4, 7);
        err_en = 1'b1; err_addr = 32'h7004;
        reg_wr(3'd2, 32'h7000); reg_wr(3'd3, 32'h8000); reg_wr(3'd1, 3);
        expect_item(32'h8000, mv(32'h7000), 2'b10);
        reg_wr(3'd0, ctrl(1,0,0,1,0,0,1,1,2'b10,2'b10,2'b00,1));
        repeat (40) @(negedge clk);
        err_en = 1'b0;
        check("R11", exp_q.size(), 0, "one item before error");
        reg_rd(3'd0, r); check("R11", r[0], 0, "enable cleared");
        reg_rd(3'd1, r); check("R11", r, 2, "failed item not counted");
        reg_rd(3'd4, r); check("R11", r, 4, "error flag only");
        check("R12", irq, 1, "irq from error");
        reg_wr(3'd4, 1);
        reg_rd(3'd4, r); check("R12", r, 4, "clearing tc leaves error");

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule